// File: doc/BRIEF.md
# SDRAM Start-up and Command Spacing Sequencer

This block sits between a memory controller's request logic and the SDRAM command pins. When its enable input goes high it waits a programmable number of clock cycles for supplies and the memory clock to settle. It then issues the fixed start-up series: precharge of all banks, one auto-refresh and a mode-register load. After that it raises a done flag and accepts requests for ACTIVE, PRECHARGE and REFRESH commands.

Each request is held until the minimum gap that governs it has run out. The gaps are refresh-to-active, mode-load-to-active and active-to-precharge. Each gap comes from a small field that can be changed at run time. A field is read at the moment its gap starts, so a later change does not alter a gap already running. Dropping enable aborts everything and puts the command pins in the inhibit state. The next enable repeats the whole start-up series.

Top module: `sdram_cmd_seq`

## Requirements
- R1: While reset is high or enable is low, the command output is inhibit (`{cs,ras,cas,we}` = 4'b1111) from the next clock edge, and ready and init-done are low.
- R2: While enabled, any cycle that carries no command shows NOP (4'b0111).
- R3: With start-up wait N, the first rising edge that samples enable high is followed by N NOP cycles, and precharge-all (4'b0010) appears on the (N+1)th edge after that first one.
- R4: Precharge-all is followed on consecutive edges by auto-refresh (4'b0001) and then mode load (4'b0000).
- R5: Init-done rises exactly one cycle after the mode-load command appears.
- R6: Activate, precharge and refresh request strobes sampled while init-done is low are discarded and never produce a command.
- R7: An ACTIVE (4'b0011) leaves at least m idle cycles after the mode load and at least r idle cycles after any REFRESH, where m and r are the 2-bit and 3-bit gap fields, each code meaning that many cycles.
- R8: A PRECHARGE leaves at least a idle cycles after the latest ACTIVE, where a is the 3-bit gap field.
- R9: A gap of zero lets the next command follow on the very next cycle, and a strobe sampled while its gap is open issues at that same edge.
- R10: Once init-done is high, ready is low exactly while an accepted request is still waiting.
- R11: When several requests can go in the same cycle, REFRESH wins over PRECHARGE, which wins over ACTIVE, and only one command goes per cycle.
- R12: A gap field is read when its gap starts, and changing it during the count leaves that gap's length unchanged.
- R13: Clearing enable drops all waiting requests, and the next enable repeats the full start-up series with a fresh wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Sequencer enable |
| init_wait_i | input | 14 | Start-up wait in cycles |
| mr_gap_i | input | 2 | Mode-load to ACTIVE gap |
| rf_gap_i | input | 3 | REFRESH to ACTIVE gap |
| ap_gap_i | input | 3 | ACTIVE to PRECHARGE gap |
| act_req_i | input | 1 | ACTIVE request strobe |
| pre_req_i | input | 1 | PRECHARGE request strobe |
| ref_req_i | input | 1 | REFRESH request strobe |
| cmd_o | output | 4 | Command as {cs, ras, cas, we} |
| ready_o | output | 1 | No accepted request is waiting |
| init_done_o | output | 1 | Start-up series complete |

## Verification
A start-up state that slips by one shows at once on cmd_o, because precharge-all then lands one edge early or late against the wait field. A gap counter that loads the wrong value, or that re-reads its field, shows up the first time a request follows its governing command. The request then appears on a different edge than the one computed from the field, and ready stays low for the wrong number of cycles. Pending flags that survive a disable would show as a stray command right after the next start-up series, before any new strobe arrives.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    // Command encoding on the pins, bit order {cs, ras, cas, we}
    typedef enum logic [3:0] {
        CMD_INHIBIT   = 4'b1111,
        CMD_NOP       = 4'b0111,
        CMD_ACTIVE    = 4'b0011,
        CMD_PRECHARGE = 4'b0010,
        CMD_REFRESH   = 4'b0001,
        CMD_LOAD_MODE = 4'b0000
    } sdram_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_BOOT_WAIT,
        ST_AUTO_REF,
        ST_LOAD_MODE,
        ST_RUN
    } seq_state_e;

    // One bit per serviced request kind
    typedef struct packed {
        logic refr;
        logic pre;
        logic act;
    } req_set_t;

    // Fixed priority: refresh, then precharge, then activate
    function automatic req_set_t pick_grant(input req_set_t want,
                                            input logic act_open,
                                            input logic pre_open);
        req_set_t g;
        g = '0;
        if (want.refr)                g.refr = 1'b1;
        else if (want.pre && pre_open) g.pre  = 1'b1;
        else if (want.act && act_open) g.act  = 1'b1;
        return g;
    endfunction

endpackage

// File: rtl/sdram_gap_timer.sv
module sdram_gap_timer #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         open_o
);
    logic [W-1:0] cnt_q;
    logic [W-1:0] dec;

    always_comb begin
        dec = (cnt_q == '0) ? '0 : cnt_q - 1'b1;
    end

    // A new load never shortens a gap that is still running
    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt_q <= '0;
        else if (load)
            cnt_q <= (load_val > dec) ? load_val : dec;
        else
            cnt_q <= dec;
    end

    assign open_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_fsm.sv
module sdram_init_fsm
    import sdram_seq_pkg::*;
#(
    parameter int unsigned BOOT_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [BOOT_W-1:0] boot_wait_i,
    output logic              init_done_o,
    output logic              init_issue_o,
    output sdram_cmd_e        init_cmd_o
);
    seq_state_e        state_q, state_d;
    logic [BOOT_W-1:0] boot_q, boot_d;
    logic              done_q;

    always_comb begin
        state_d      = state_q;
        boot_d       = boot_q;
        init_issue_o = 1'b0;
        init_cmd_o   = CMD_NOP;
        if (!en_i) begin
            state_d = ST_IDLE;
            boot_d  = '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    state_d = ST_BOOT_WAIT;
                    boot_d  = boot_wait_i;
                end
                ST_BOOT_WAIT: begin
                    if (boot_q == '0) begin
                        init_issue_o = 1'b1;
                        init_cmd_o   = CMD_PRECHARGE;
                        state_d      = ST_AUTO_REF;
                    end else begin
                        boot_d = boot_q - 1'b1;
                    end
                end
                ST_AUTO_REF: begin
                    init_issue_o = 1'b1;
                    init_cmd_o   = CMD_REFRESH;
                    state_d      = ST_LOAD_MODE;
                end
                ST_LOAD_MODE: begin
                    init_issue_o = 1'b1;
                    init_cmd_o   = CMD_LOAD_MODE;
                    state_d      = ST_RUN;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            boot_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            boot_q  <= boot_d;
            done_q  <= en_i && (state_q == ST_RUN);
        end
    end

    assign init_done_o = done_q;
endmodule

// File: rtl/sdram_req_arbiter.sv
module sdram_req_arbiter
    import sdram_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     accept,
    input  req_set_t req_i,
    input  logic     act_open,
    input  logic     pre_open,
    output req_set_t grant_o,
    output logic     pending_o
);
    req_set_t pend_q;
    req_set_t want;

    always_comb begin
        want    = accept ? (pend_q | req_i) : pend_q;
        grant_o = pick_grant(want, act_open, pre_open);
    end

    always_ff @(posedge clk) begin
        if (rst || clr)
            pend_q <= '0;
        else
            pend_q <= want & ~grant_o;
    end

    assign pending_o = |pend_q;
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int unsigned BOOT_W = 14,
    parameter int unsigned MR_W   = 2,
    parameter int unsigned RF_W   = 3,
    parameter int unsigned AP_W   = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en_i,
    input  logic [BOOT_W-1:0] init_wait_i,
    input  logic [MR_W-1:0]   mr_gap_i,
    input  logic [RF_W-1:0]   rf_gap_i,
    input  logic [AP_W-1:0]   ap_gap_i,
    input  logic              act_req_i,
    input  logic              pre_req_i,
    input  logic              ref_req_i,
    output logic [3:0]        cmd_o,
    output logic              ready_o,
    output logic              init_done_o
);
    localparam int unsigned ACT_W = (MR_W > RF_W) ? MR_W : RF_W;

    logic       init_issue;
    sdram_cmd_e init_cmd;
    logic       done;
    logic       act_open, pre_open, pending;
    req_set_t   reqs, grant;
    sdram_cmd_e issue_cmd, cmd_q;
    logic       act_load, pre_load;
    logic [ACT_W-1:0] act_val;

    assign reqs = '{refr: ref_req_i, pre: pre_req_i, act: act_req_i};

    sdram_init_fsm #(.BOOT_W(BOOT_W)) u_init (
        .clk         (clk),
        .rst         (rst),
        .en_i        (en_i),
        .boot_wait_i (init_wait_i),
        .init_done_o (done),
        .init_issue_o(init_issue),
        .init_cmd_o  (init_cmd)
    );

    sdram_req_arbiter u_arb (
        .clk      (clk),
        .rst      (rst),
        .clr      (!en_i),
        .accept   (done && en_i),
        .req_i    (reqs),
        .act_open (act_open),
        .pre_open (pre_open),
        .grant_o  (grant),
        .pending_o(pending)
    );

    always_comb begin
        if (init_issue)      issue_cmd = init_cmd;
        else if (grant.refr) issue_cmd = CMD_REFRESH;
        else if (grant.pre)  issue_cmd = CMD_PRECHARGE;
        else if (grant.act)  issue_cmd = CMD_ACTIVE;
        else                 issue_cmd = CMD_NOP;
    end

    // ACTIVE gate: started by refresh or by mode load
    always_comb begin
        act_load = (issue_cmd == CMD_REFRESH) || (issue_cmd == CMD_LOAD_MODE);
        act_val  = (issue_cmd == CMD_REFRESH) ? ACT_W'(rf_gap_i) : ACT_W'(mr_gap_i);
        pre_load = (issue_cmd == CMD_ACTIVE);
    end

    sdram_gap_timer #(.W(ACT_W)) u_act_gap (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en_i),
        .load    (act_load),
        .load_val(act_val),
        .open_o  (act_open)
    );

    sdram_gap_timer #(.W(AP_W)) u_pre_gap (
        .clk     (clk),
        .rst     (rst),
        .clr     (!en_i),
        .load    (pre_load),
        .load_val(ap_gap_i),
        .open_o  (pre_open)
    );

    always_ff @(posedge clk) begin
        if (rst || !en_i)
            cmd_q <= CMD_INHIBIT;
        else
            cmd_q <= issue_cmd;
    end

    assign cmd_o       = cmd_q;
    assign init_done_o = done;
    assign ready_o     = done && !pending;
endmodule

// File: rtl/sdram_cmd_seq_chk.sv
module sdram_cmd_seq_chk
    import sdram_seq_pkg::*;
#(
    parameter int unsigned AP_W = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            en_i,
    input logic [AP_W-1:0] ap_gap_i,
    input logic [3:0]      cmd_o,
    input logic            ready_o,
    input logic            init_done_o
);
    // Idle cycles seen since the latest ACTIVE, with its gap field
    logic [AP_W-1:0] ap_prev, ap_need;
    logic [AP_W:0]   since_act;
    logic            armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_prev   <= '0;
            ap_need   <= '0;
            since_act <= '0;
            armed     <= 1'b0;
        end else begin
            ap_prev <= ap_gap_i;
            if (!en_i) begin
                armed     <= 1'b0;
                since_act <= '0;
            end else if (cmd_o == CMD_ACTIVE) begin
                armed     <= 1'b1;
                ap_need   <= ap_prev;
                since_act <= '0;
            end else if (cmd_o != CMD_PRECHARGE && since_act != '1) begin
                since_act <= since_act + 1'b1;
            end
        end
    end

    a_r1_inhibit_when_off: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (cmd_o == CMD_INHIBIT && !init_done_o && !ready_o));

    a_r2_enabled_drives: assert property (@(posedge clk) disable iff (rst)
        en_i |=> (cmd_o != CMD_INHIBIT));

    a_r5_done_after_load: assert property (@(posedge clk) disable iff (rst)
        $rose(init_done_o) |-> ($past(cmd_o) == CMD_LOAD_MODE));

    a_r6_no_active_early: assert property (@(posedge clk) disable iff (rst)
        !init_done_o |-> (cmd_o != CMD_ACTIVE));

    a_r10_ready_needs_done: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> init_done_o);

    a_r8_act_to_pre_gap: assert property (@(posedge clk) disable iff (rst)
        (armed && en_i && cmd_o == CMD_PRECHARGE) |-> (since_act >= {1'b0, ap_need}));
endmodule

bind sdram_cmd_seq sdram_cmd_seq_chk #(.AP_W(AP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_i),
    .ap_gap_i   (ap_gap_i),
    .cmd_o      (cmd_o),
    .ready_o    (ready_o),
    .init_done_o(init_done_o)
);

// File: tb/sdram_cmd_seq_tb.sv
module sdram_cmd_seq_tb;
    localparam logic [3:0] K_INH = 4'b1111;
    localparam logic [3:0] K_NOP = 4'b0111;
    localparam logic [3:0] K_ACT = 4'b0011;
    localparam logic [3:0] K_PRE = 4'b0010;
    localparam logic [3:0] K_REF = 4'b0001;
    localparam logic [3:0] K_LMR = 4'b0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [13:0] init_wait = '0;
    logic [1:0]  mr_gap = '0;
    logic [2:0]  rf_gap = '0;
    logic [2:0]  ap_gap = '0;
    logic        act_req = 1'b0;
    logic        pre_req = 1'b0;
    logic        ref_req = 1'b0;
    logic [3:0]  cmd;
    logic        ready;
    logic        init_done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #5 clk = ~clk;

    sdram_cmd_seq u_dut (
        .clk        (clk),
        .rst        (rst),
        .en_i       (en),
        .init_wait_i(init_wait),
        .mr_gap_i   (mr_gap),
        .rf_gap_i   (rf_gap),
        .ap_gap_i   (ap_gap),
        .act_req_i  (act_req),
        .pre_req_i  (pre_req),
        .ref_req_i  (ref_req),
        .cmd_o      (cmd),
        .ready_o    (ready),
        .init_done_o(init_done)
    );

    task automatic check(input bit ok, input string tag, input int got, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // Strobe a set of requests for one edge, then count samples until want shows
    task automatic fire(input bit a, input bit p, input bit r, input logic [3:0] want,
                        output int n, output bit ready_low_while_waiting);
        act_req = a; pre_req = p; ref_req = r;
        step();
        act_req = 1'b0; pre_req = 1'b0; ref_req = 1'b0;
        n = 1;
        ready_low_while_waiting = 1'b1;
        while (cmd != want && n < 40) begin
            if (ready) ready_low_while_waiting = 1'b0;
            step();
            n++;
        end
    endtask

    // Full start-up; leaves time at the sample after init-done rose
    task automatic do_init(input int nwait, input int m, input int r, input int a,
                           input bit poke);
        bit nop_ok;
        init_wait = 14'(nwait);
        mr_gap = 2'(m); rf_gap = 3'(r); ap_gap = 3'(a);
        en = 1'b1;
        nop_ok = 1'b1;
        for (int i = 0; i <= nwait; i++) begin
            if (poke && i == 2) begin act_req = 1'b1; pre_req = 1'b1; ref_req = 1'b1; end
            step();
            act_req = 1'b0; pre_req = 1'b0; ref_req = 1'b0;
            if (cmd != K_NOP || init_done) nop_ok = 1'b0;
        end
        check(nop_ok, "R2/R3 NOP during start-up wait", int'(cmd), int'(K_NOP));
        step();
        check(cmd == K_PRE, "R3 precharge-all after wait", int'(cmd), int'(K_PRE));
        step();
        check(cmd == K_REF, "R4 auto-refresh second", int'(cmd), int'(K_REF));
        step();
        check(cmd == K_LMR && !init_done, "R4 mode load third, done low",
              int'(cmd), int'(K_LMR));
        step();
        check(init_done && cmd == K_NOP, "R5 done one cycle after mode load",
              int'(init_done), 1);
        check(ready, "R10 ready high with nothing waiting", int'(ready), 1);
    endtask

    task automatic t_reset();
        repeat (3) step();
        check(cmd == K_INH, "R1 inhibit in reset", int'(cmd), int'(K_INH));
        check(!ready && !init_done, "R1 flags low in reset", int'({ready, init_done}), 0);
        rst = 1'b0;
        step();
        check(cmd == K_INH, "R1 inhibit while disabled", int'(cmd), int'(K_INH));
    endtask

    task automatic t_ignore_early();
        bit quiet;
        do_init(6, 0, 0, 0, 1'b1);
        quiet = 1'b1;
        for (int i = 0; i < 5; i++) begin
            if (cmd != K_NOP || !ready) quiet = 1'b0;
            step();
        end
        check(quiet, "R6 early strobes discarded", int'(cmd), int'(K_NOP));
    endtask

    task automatic restart();
        en = 1'b0;
        step();
        check(cmd == K_INH && !init_done, "R13 disable gives inhibit", int'(cmd), int'(K_INH));
    endtask

    // ACTIVE right after start-up, then PRECHARGE after it
    task automatic t_lmr_act_pre(input int m, input int r, input int a);
        int n, e;
        bit rl;
        restart();
        do_init(2, m, r, a, 1'b0);
        e = 1;
        if (r - 1 > e) e = r - 1;
        if (m > e) e = m;
        fire(1'b1, 1'b0, 1'b0, K_ACT, n, rl);
        check(n == e, $sformatf("R7/R9 ACTIVE after mode load m=%0d r=%0d", m, r), n, e);
        check(rl && ready, "R10 ready low only while ACTIVE waits", int'(rl), 1);
        fire(1'b0, 1'b1, 1'b0, K_PRE, n, rl);
        check(n == a + 1, $sformatf("R8/R9 PRECHARGE after ACTIVE a=%0d", a), n, a + 1);
    endtask

    task automatic t_ref_act(input int r);
        int n;
        bit rl;
        rf_gap = 3'(r);
        repeat (10) step();
        fire(1'b0, 1'b0, 1'b1, K_REF, n, rl);
        check(n == 1, "R9 refresh issues at the strobe edge", n, 1);
        fire(1'b1, 1'b0, 1'b0, K_ACT, n, rl);
        check(n == r + 1, $sformatf("R7 ACTIVE after REFRESH r=%0d", r), n, r + 1);
    endtask

    task automatic t_snapshot();
        int n;
        bit rl;
        rf_gap = 3'd6;
        repeat (10) step();
        fire(1'b0, 1'b0, 1'b1, K_REF, n, rl);
        act_req = 1'b1;
        step();
        act_req = 1'b0;
        rf_gap = 3'd0;
        n = 1;
        while (cmd != K_ACT && n < 40) begin
            step();
            n++;
        end
        check(n == 7, "R12 field change mid-gap ignored", n, 7);
    endtask

    task automatic t_priority();
        int n;
        bit rl;
        rf_gap = 3'd2;
        repeat (10) step();
        act_req = 1'b1; pre_req = 1'b1; ref_req = 1'b1;
        step();
        act_req = 1'b0; pre_req = 1'b0; ref_req = 1'b0;
        check(cmd == K_REF && !ready, "R11 refresh first", int'(cmd), int'(K_REF));
        step();
        check(cmd == K_PRE && !ready, "R11 precharge second", int'(cmd), int'(K_PRE));
        step();
        check(cmd == K_NOP && !ready, "R11 ACTIVE held by refresh gap", int'(cmd), int'(K_NOP));
        step();
        check(cmd == K_ACT && ready, "R11/R10 ACTIVE last, ready back", int'(cmd), int'(K_ACT));
        n = 0; rl = 1'b0;
    endtask

    task automatic t_abort();
        bit clean;
        int n;
        bit rl;
        // Leave an ACTIVE waiting, then disable
        rf_gap = 3'd7;
        repeat (10) step();
        ref_req = 1'b1; step(); ref_req = 1'b0;
        act_req = 1'b1; step(); act_req = 1'b0;
        check(!ready, "R10 ready low with ACTIVE waiting", int'(ready), 0);
        restart();
        init_wait = 14'd60;
        en = 1'b1;
        repeat (5) step();
        restart();
        do_init(3, 0, 0, 0, 1'b0);
        clean = 1'b1;
        for (int i = 0; i < 10; i++) begin
            if (cmd != K_NOP) clean = 1'b0;
            step();
        end
        check(clean, "R13 waiting request dropped by disable", int'(cmd), int'(K_NOP));
        fire(1'b1, 1'b0, 1'b0, K_ACT, n, rl);
        check(n == 1, "R13 service resumes after restart", n, 1);
    endtask

    initial begin
        t_reset();
        t_ignore_early();
        t_lmr_act_pre(1, 7, 5);
        t_lmr_act_pre(3, 0, 0);
        t_lmr_act_pre(0, 0, 7);
        t_ref_act(4);
        t_ref_act(0);
        t_snapshot();
        t_priority();
        t_abort();
        restart();
        do_init(300, 2, 3, 1, 1'b0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got %0d expected %0d", 1, 0);
            finish_run();
        end
    end
endmodule